// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Service Lock and Inhibits

The block keeps a set of pending interrupt request cells, one per peripheral source, and tells the processor sequencer when an interrupt may be taken. Peripherals raise a request with a one-cycle set pulse. The request stays pending until it is killed or the block is reset. The lowest-numbered pending cell has priority, and its number (1 upward, 0 for none) is the priority code.

The sequencer sends single-cycle control pulses. A latch pulse copies the priority code into a service register. While that register is nonzero, no further interrupt is requested, so interrupts do not nest. A kill pulse retires the cell being served. A clear pulse empties the service register.

Two inhibits also gate the request. The first is a one-instruction inhibit, armed only when a write to the accumulator overflows and cleared by its own pulse. The second is a program inhibit, set by an inhibit pulse or by reset and cleared by a release pulse. A vector read pulse drives the entry address of the served source onto the read bus. The addresses start at a fixed base and are spaced four words apart.

Top module: `pri_int_ctrl`

## Requirements
- R1: While rst_ni is low, the block holds these values: svc_num_o = 0, all request cells clear, the one-instruction inhibit clear, the program inhibit set, irq_o = 0 and rd_bus_o = 0.
- R2: The priority code is k+1 for the lowest index k whose request cell is set, and 0 when no cell is set. Index 0 has the highest priority.
- R3: irq_o is 1 only when all four of these hold: the priority code is nonzero, svc_num_o is 0, the one-instruction inhibit is clear, and the program inhibit is clear.
- R4: On a clock edge with latch_i high, svc_num_o takes the priority code the cells held before that edge. If clear_i is also high on that edge, clear_i wins and svc_num_o becomes 0.
- R5: On a clock edge with kill_i high, the cell with index svc_num_o-1 is cleared. kill_i has no effect when svc_num_o is 0. If req_set_i sets the same cell on the same edge, the cell stays set.
- R6: On a clock edge with clear_i high, svc_num_o becomes 0.
- R7: A one-cycle pulse on req_set_i[k] sets cell k. The cell then stays set across any number of cycles until it is killed or reset.
- R8: While vec_rd_i is high and svc_num_o is nonzero, rd_bus_o equals 1024 (octal 2000) + 4*(svc_num_o-1). In every other case rd_bus_o is 0.
- R9: On a clock edge with ovf_wr_i high, the one-instruction inhibit is set if wr_data_i[15] differs from wr_data_i[14]; otherwise it is left unchanged. clr_inh1_i clears it. When both arrive on the same edge, the set wins.
- R10: inh_i sets the program inhibit and rel_i clears it. When both arrive on the same edge, inh_i wins.
- R11: A gen_rst_i pulse has the same effect as R1 on the next edge, and it overrides every other pulse on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | NUM_REQ (6) | One-cycle request set pulses, one per cell |
| gen_rst_i | input | 1 | Synchronous general reset pulse |
| latch_i | input | 1 | Copy the priority code into the service register |
| kill_i | input | 1 | Clear the cell now in service |
| clear_i | input | 1 | Empty the service register |
| ovf_wr_i | input | 1 | Accumulator write strobe; arms the inhibit on overflow |
| wr_data_i | input | DATA_W (16) | Write bus value tested for overflow |
| clr_inh1_i | input | 1 | Clear the one-instruction inhibit |
| inh_i | input | 1 | Set the program inhibit |
| rel_i | input | 1 | Release the program inhibit |
| vec_rd_i | input | 1 | Drive the vector address onto rd_bus_o |
| irq_o | output | 1 | Interrupt request to the sequencer |
| svc_num_o | output | SVC_W (3) | Service register: 0 means idle, otherwise 1..NUM_REQ |
| rd_bus_o | output | DATA_W (16) | Vector address, or 0 |

## Verification
The bench builds the block with its default values: six cells, a 16-bit bus, base 1024 and a stride of four words. These values let it reach every priority code from 1 to 6, including the last cell, whose address is 1044. They also let it reach both overflow polarities, the two bit-15/14 patterns that do not overflow, and every same-edge conflict pair: set/kill, latch/clear, inhibit/release, arm/clear and general reset.

// File: rtl/pri_int_pkg.sv
package pri_int_pkg;
  localparam int unsigned NUM_REQ_DEF = 6;
  localparam int unsigned DATA_W_DEF  = 16;
  localparam int unsigned VEC_BASE_DEF = 1024;  // octal 2000
  localparam int unsigned STRIDE_LOG2_DEF = 2;
endpackage

// File: rtl/pri_req_cells.sv
module pri_req_cells #(
  parameter int unsigned NUM_REQ = 6,
  localparam int unsigned SVC_W = $clog2(NUM_REQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_set_i,
  input  logic               gen_rst_i,
  input  logic               kill_i,
  input  logic [SVC_W-1:0]   svc_num_i,
  output logic [SVC_W-1:0]   prio_o
);
  logic [NUM_REQ-1:0] pend_q;

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_cell
    logic kill_hit;
    assign kill_hit = kill_i && (svc_num_i == SVC_W'(k + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          pend_q[k] <= 1'b0;
      else if (gen_rst_i)   pend_q[k] <= 1'b0;
      else if (req_set_i[k]) pend_q[k] <= 1'b1;  // set beats kill
      else if (kill_hit)    pend_q[k] <= 1'b0;
    end

    a_r5_kill_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kill_i && svc_num_i == SVC_W'(k + 1) && !req_set_i[k]) |=> !pend_q[k]);
    a_r7_cell_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[k] && !gen_rst_i && !(kill_i && svc_num_i == SVC_W'(k + 1))) |=> pend_q[k]);
  end

  always_comb begin
    prio_o = '0;
    for (int k = NUM_REQ - 1; k >= 0; k--)
      if (pend_q[k]) prio_o = SVC_W'(k + 1);
  end

  a_r2_code_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |-> (prio_o == '0));
endmodule

// File: rtl/pri_svc_reg.sv
module pri_svc_reg #(
  parameter int unsigned NUM_REQ = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned VEC_BASE = 1024,
  parameter int unsigned STRIDE_LOG2 = 2,
  localparam int unsigned SVC_W = $clog2(NUM_REQ + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_rst_i,
  input  logic              latch_i,
  input  logic              clear_i,
  input  logic              vec_rd_i,
  input  logic [SVC_W-1:0]  prio_i,
  output logic [SVC_W-1:0]  svc_num_o,
  output logic [DATA_W-1:0] rd_bus_o
);
  logic [SVC_W-1:0] svc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   svc_q <= '0;
    else if (gen_rst_i || clear_i) svc_q <= '0;
    else if (latch_i)              svc_q <= prio_i;
  end

  assign svc_num_o = svc_q;

  logic [DATA_W-1:0] offs;
  assign offs = DATA_W'(svc_q - SVC_W'(1)) << STRIDE_LOG2;
  assign rd_bus_o = (vec_rd_i && svc_q != '0) ? DATA_W'(VEC_BASE) + offs : '0;

  a_r4_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !clear_i && !gen_rst_i) |=> (svc_q == $past(prio_i)));
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (svc_q == '0));
  a_r8_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_q == '0) |-> (rd_bus_o == '0));
endmodule

// File: rtl/pri_inhibit.sv
module pri_inhibit #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_rst_i,
  input  logic              ovf_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_inh1_i,
  input  logic              inh_i,
  input  logic              rel_i,
  output logic              inh1_o,
  output logic              inh_o
);
  logic inh1_q, inh_q, ovf;
  // top two bits disagree: positive or negative overflow
  assign ovf = wr_data_i[DATA_W-1] ^ wr_data_i[DATA_W-2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inh1_q <= 1'b0;
      inh_q  <= 1'b1;
    end else if (gen_rst_i) begin
      inh1_q <= 1'b0;
      inh_q  <= 1'b1;
    end else begin
      if (ovf_wr_i && ovf) inh1_q <= 1'b1;
      else if (clr_inh1_i) inh1_q <= 1'b0;
      if (inh_i)           inh_q <= 1'b1;
      else if (rel_i)      inh_q <= 1'b0;
    end
  end

  assign inh1_o = inh1_q;
  assign inh_o  = inh_q;

  a_r9_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_wr_i && (wr_data_i[DATA_W-1] != wr_data_i[DATA_W-2])) |=> inh1_q);
  a_r9_no_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inh1_q && !(ovf_wr_i && (wr_data_i[DATA_W-1] != wr_data_i[DATA_W-2]))) |=> !inh1_q);
  a_r10_inh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_i |=> inh_q);
  a_r11_gen_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_rst_i |=> (inh_q && !inh1_q));
endmodule

// File: rtl/pri_int_ctrl.sv
module pri_int_ctrl
  import pri_int_pkg::*;
#(
  parameter int unsigned NUM_REQ = NUM_REQ_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned VEC_BASE = VEC_BASE_DEF,
  parameter int unsigned STRIDE_LOG2 = STRIDE_LOG2_DEF,
  localparam int unsigned SVC_W = $clog2(NUM_REQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_set_i,
  input  logic               gen_rst_i,
  input  logic               latch_i,
  input  logic               kill_i,
  input  logic               clear_i,
  input  logic               ovf_wr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               clr_inh1_i,
  input  logic               inh_i,
  input  logic               rel_i,
  input  logic               vec_rd_i,
  output logic               irq_o,
  output logic [SVC_W-1:0]   svc_num_o,
  output logic [DATA_W-1:0]  rd_bus_o
);
  logic [SVC_W-1:0] prio;
  logic inh1, inh;

  pri_req_cells #(.NUM_REQ(NUM_REQ)) u_cells (
    .clk_i, .rst_ni, .req_set_i, .gen_rst_i, .kill_i,
    .svc_num_i(svc_num_o), .prio_o(prio)
  );

  pri_svc_reg #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE),
                .STRIDE_LOG2(STRIDE_LOG2)) u_svc (
    .clk_i, .rst_ni, .gen_rst_i, .latch_i, .clear_i, .vec_rd_i,
    .prio_i(prio), .svc_num_o, .rd_bus_o
  );

  pri_inhibit #(.DATA_W(DATA_W)) u_inh (
    .clk_i, .rst_ni, .gen_rst_i, .ovf_wr_i, .wr_data_i, .clr_inh1_i,
    .inh_i, .rel_i, .inh1_o(inh1), .inh_o(inh)
  );

  assign irq_o = (prio != '0) && (svc_num_o == '0) && !inh1 && !inh;

  a_r3_no_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_num_o != '0) |-> !irq_o);
  a_r3_inhibited: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh || inh1) |-> !irq_o);
  a_r11_gen_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_rst_i |=> (svc_num_o == '0 && !irq_o));
endmodule

// File: tb/tb_pri_int_ctrl.sv
`timescale 1ns/1ps
module tb_pri_int_ctrl;
  logic clk = 0, rst_ni = 0;
  logic [5:0] req_set_i = '0;
  logic gen_rst_i = 0, latch_i = 0, kill_i = 0, clear_i = 0, ovf_wr_i = 0;
  logic [15:0] wr_data_i = '0;
  logic clr_inh1_i = 0, inh_i = 0, rel_i = 0, vec_rd_i = 0;
  logic irq_o;
  logic [2:0] svc_num_o;
  logic [15:0] rd_bus_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pri_int_ctrl dut (.clk_i(clk), .rst_ni, .req_set_i, .gen_rst_i, .latch_i,
    .kill_i, .clear_i, .ovf_wr_i, .wr_data_i, .clr_inh1_i, .inh_i, .rel_i,
    .vec_rd_i, .irq_o, .svc_num_o, .rd_bus_o);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // apply pulses already set, then release them 1 ns after the edge
  task automatic tick();
    @(posedge clk); #1;
    req_set_i = '0; gen_rst_i = 0; latch_i = 0; kill_i = 0; clear_i = 0;
    ovf_wr_i = 0; clr_inh1_i = 0; inh_i = 0; rel_i = 0;
  endtask

  task automatic latch_clr_check(string req, int exp);
    latch_i = 1; tick(); chk(req, svc_num_o, exp);
    clear_i = 1; tick();
  endtask

  task automatic t_reset();
    vec_rd_i = 1; #1;
    chk("R1 svc", svc_num_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 bus", rd_bus_o, 0);
    vec_rd_i = 0;
    @(negedge clk); rst_ni = 1; @(negedge clk);
    latch_clr_check("R1 cells clear", 0);
  endtask

  task automatic t_inhibit();
    req_set_i[2] = 1; tick();
    chk("R10 irq held by inhibit after reset", irq_o, 0);
    rel_i = 1; tick(); chk("R3 irq raised", irq_o, 1);
    inh_i = 1; tick(); chk("R10 inhibit", irq_o, 0);
    inh_i = 1; rel_i = 1; tick(); chk("R10 inh wins", irq_o, 0);
    rel_i = 1; tick(); chk("R10 release", irq_o, 1);
  endtask

  task automatic t_priority();
    req_set_i[4] = 1; tick();
    latch_i = 1; tick(); chk("R2 cell2 over cell4", svc_num_o, 3);
    chk("R3 no nest", irq_o, 0);
    vec_rd_i = 1; #1; chk("R8 vec svc3", rd_bus_o, 1032); vec_rd_i = 0; #1;
    chk("R8 bus idle without read", rd_bus_o, 0);
    req_set_i[0] = 1; tick();
    chk("R4 svc stays w/o latch", svc_num_o, 3);
    chk("R3 pending but in service", irq_o, 0);
    clear_i = 1; tick(); chk("R6 clear", svc_num_o, 0);
    chk("R3 irq after clear", irq_o, 1);
    latch_i = 1; clear_i = 1; tick(); chk("R4 clear beats latch", svc_num_o, 0);
    latch_i = 1; tick(); chk("R2 cell0 wins", svc_num_o, 1);
    vec_rd_i = 1; #1; chk("R8 vec svc1", rd_bus_o, 1024); vec_rd_i = 0;
  endtask

  task automatic t_kill();
    kill_i = 1; tick(); clear_i = 1; tick();
    latch_clr_check("R5 cell0 killed", 3);
    latch_i = 1; tick();
    kill_i = 1; req_set_i[2] = 1; tick();
    clear_i = 1; tick();
    latch_clr_check("R5 set beats kill", 3);
    repeat (3) tick();
    latch_clr_check("R7 cell persists", 3);
    latch_i = 1; tick(); kill_i = 1; tick(); clear_i = 1; tick();
    latch_i = 1; tick(); chk("R2 cell4 next", svc_num_o, 5);
    vec_rd_i = 1; #1; chk("R8 vec svc5", rd_bus_o, 1040); vec_rd_i = 0;
    kill_i = 1; tick(); clear_i = 1; tick();
    latch_clr_check("R2 none pending", 0);
    kill_i = 1; req_set_i[5] = 1; tick();  // svc 0: kill must do nothing
    kill_i = 1; tick();
    latch_i = 1; tick(); chk("R5 kill idle no effect", svc_num_o, 6);
    vec_rd_i = 1; #1; chk("R8 vec svc6", rd_bus_o, 1044); vec_rd_i = 0;
    clear_i = 1; tick();
  endtask

  task automatic ovf_case(string req, logic [15:0] d, int exp_irq);
    ovf_wr_i = 1; wr_data_i = d; tick();
    chk(req, irq_o, exp_irq);
    clr_inh1_i = 1; tick();
    chk("R9 cleared", irq_o, 1);
  endtask

  task automatic t_overflow();
    chk("R3 baseline irq", irq_o, 1);
    ovf_case("R9 pos ovf 4000", 16'h4000, 0);
    ovf_case("R9 neg ovf 8000", 16'h8000, 0);
    ovf_case("R9 pos ovf 7fff", 16'h7fff, 0);
    ovf_case("R9 no ovf 3fff", 16'h3fff, 1);
    ovf_case("R9 no ovf c000", 16'hc000, 1);
    ovf_wr_i = 1; wr_data_i = 16'h4000; clr_inh1_i = 1; tick();
    chk("R9 arm beats clear", irq_o, 0);
    clr_inh1_i = 1; tick(); chk("R9 clear", irq_o, 1);
  endtask

  task automatic t_genrst();
    latch_i = 1; tick();
    gen_rst_i = 1; inh_i = 0; rel_i = 1; req_set_i[1] = 1; latch_i = 1; tick();
    chk("R11 svc", svc_num_o, 0);
    chk("R11 irq", irq_o, 0);
    rel_i = 1; tick(); chk("R11 cells cleared", irq_o, 0);
    latch_clr_check("R11 no pending", 0);
  endtask

  initial begin
    t_reset();
    t_inhibit();
    t_priority();
    t_kill();
    t_overflow();
    t_genrst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule